// File: doc/BRIEF.md
# Banked GPIO Register Controller

This block is a memory-mapped general-purpose I/O port with a plain register bus: a byte address, a write strobe, a 32-bit write word and a registered 32-bit read word. The pins are split into groups of 32. Each group has five registers: a direction word, an output latch, a write-one-to-set port and a write-one-to-clear port for that latch, and a read-only word that returns the synchronized pin levels. With the default of 71 pins there are three groups, and the last one implements only its low 7 bits.

Software changes single pins without a read-modify-write by writing a mask to the set or clear port. The latch drives the pad output at all times. The pad output enable is on only for pins whose direction bit is 0. Pin levels pass through a two-flop synchronizer before they can be read. A pin that software has just driven therefore reads back its old level for a few cycles. Bus writes are staged one cycle before they reach the registers.

Top module: `gpio_ctrl`

## Requirements
- R1: After reset every direction bit reads 1 (input), every output latch bit reads 0, `pad_oe` is all zero and `rd_data` is zero.
- R2: A direction bit of 1 makes the pin an input (`pad_oe` bit 0), and a bit of 0 makes it an output (`pad_oe` bit 1). `pad_oe` changes only after a write to a direction register.
- R3: A write to a group's set port (group offset 0x08) sets every latch bit where the word has a 1 and leaves all other latch bits as they were.
- R4: A write to a group's clear port (group offset 0x0C) clears every latch bit where the word has a 1 and leaves all other latch bits as they were.
- R5: A write to the output-latch register (group offset 0x04) replaces the latch. Reading that offset returns the latch, and `pad_out` always equals the latch whatever the direction.
- R6: The input register (group offset 0x10) returns each pin's level after a two-flop synchronizer, for output pins as well as input pins. A read issued right after a pin change, or right after a set or clear, returns the previous level.
- R7: A write presented on the bus takes effect on the registers and pads one cycle after the capturing clock edge. A read of the latch in that intermediate cycle returns the value from before the write. `rd_data` is registered one cycle after `bus_addr`.
- R8: Pin n lives in group n/32 at bit n%32. Group g starts at byte address 0x10 + 0x28*g, so the groups start at 0x10, 0x38 and 0x60. Within a group the direction register is at offset 0x00.
- R9: Bits of the last group above the highest implemented pin (bits 7 to 31 for 71 pins) read as zero and ignore writes.
- R10: The following read as zero, and writes to them change nothing: addresses outside the groups, misaligned addresses, the reserved slots at group offsets 0x14 to 0x24, and the write-only set and clear ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write word |
| rd_data | output | 32 | Registered read word for the address of the previous cycle |
| pad_in | input | 71 | Pin levels seen at the pads |
| pad_out | output | 71 | Output latch driven toward the pads |
| pad_oe | output | 71 | Pad output enable, 1 where the direction bit is 0 |

## Verification
The bench first reads the latch back in the cycle right after a set write. A design that applies bus writes without the staging cycle returns the new value there instead of the old one. It then drives pins and reads the input register at once, then again after the synchronizer has settled. A design with the wrong number of synchronizer stages returns the new level too early or too late. Pins 40 and 70 are set through their own group addresses to check the group/bit mapping. Writing all ones to the last group checks that no phantom bits read back. Writes to reserved slots, misaligned addresses and out-of-range addresses must leave every register unchanged, so a decoder that ignores the low address bits or the slot limit would corrupt a neighbouring register and be caught.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int REG_W      = 32;
  localparam int GRP_SLOTS  = 10;           // word slots reserved per group
  localparam int NUM_MAPPED = 5;            // slots actually implemented
  localparam int SLOT_BYTES = REG_W / 8;

  typedef enum logic [2:0] {
    SEL_DIR = 3'd0,
    SEL_OUT = 3'd1,
    SEL_SET = 3'd2,
    SEL_CLR = 3'd3,
    SEL_IN  = 3'd4
  } gpio_sel_e;

  function automatic int grp_width(input int pins, input int g);
    int left;
    left = pins - g * REG_W;
    return (left > REG_W) ? REG_W : left;
  endfunction
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_GRP    = 3,
  parameter int GRP_W      = 2,
  parameter int GRP_BASE   = 16,
  parameter int GRP_STRIDE = GRP_SLOTS * SLOT_BYTES
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [GRP_W-1:0]  grp,
  output gpio_sel_e         sel
);
  always_comb begin
    int unsigned a;
    int unsigned lo;
    int unsigned off;
    hit = 1'b0;
    grp = '0;
    sel = SEL_DIR;
    a   = 32'(addr);
    for (int g = 0; g < NUM_GRP; g++) begin
      lo  = 32'(GRP_BASE + g * GRP_STRIDE);
      off = a - lo;
      if (a >= lo && a < lo + 32'(GRP_STRIDE) && off[1:0] == 2'b00 &&
          (off >> 2) < 32'(NUM_MAPPED)) begin
        hit = 1'b1;
        grp = GRP_W'(g);
        sel = gpio_sel_e'(off[4:2]);
      end
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk) begin
    stage1 <= d;
    q      <= stage1;
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_v,
  input  gpio_sel_e    wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] in_o
);
  logic [W-1:0] dir_q;
  logic [W-1:0] out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q <= '1;
      out_q <= '0;
    end else if (wr_v) begin
      case (wr_sel)
        SEL_DIR: dir_q <= wr_data;
        SEL_OUT: out_q <= wr_data;
        SEL_SET: out_q <= out_q | wr_data;
        SEL_CLR: out_q <= out_q & ~wr_data;
        default: ;
      endcase
    end
  end

  gpio_sync #(.W(W)) u_sync (
    .clk (clk),
    .d   (pin_i),
    .q   (in_o)
  );

  assign dir_o = dir_q;
  assign out_o = out_q;

  // R2: direction only moves after a direction write
  p_dir_only_on_write_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(dir_q) |-> $past(wr_v && wr_sel == SEL_DIR));

  // R3: set port ORs the mask into the latch
  p_set_or_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_v && wr_sel == SEL_SET) |=> out_q == ($past(out_q) | $past(wr_data)));

  // R4: clear port removes the mask from the latch
  p_clr_andn_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_v && wr_sel == SEL_CLR) |=> out_q == ($past(out_q) & ~$past(wr_data)));

  // R5: latch holds without a write
  p_out_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !wr_v |=> $stable(out_q));

  // R6: input word lags the pins by exactly two clocks
  p_sync_lag_r6: assert property (@(posedge clk) disable iff (rst)
    in_o == $past(pin_i, 2));
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS   = 71,
  parameter int ADDR_W     = 8,
  parameter int GRP_BASE   = 16,
  parameter int GRP_STRIDE = GRP_SLOTS * SLOT_BYTES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [REG_W-1:0]    bus_wdata,
  output logic [REG_W-1:0]    rd_data,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe
);
  localparam int NUM_GRP = (NUM_PINS + REG_W - 1) / REG_W;
  localparam int GRP_W   = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
  localparam int PAD_W   = NUM_GRP * REG_W;
  localparam int LAST_W  = grp_width(NUM_PINS, NUM_GRP - 1);

  logic             dec_hit;
  logic [GRP_W-1:0] dec_grp;
  gpio_sel_e        dec_sel;

  gpio_addr_dec #(
    .ADDR_W    (ADDR_W),
    .NUM_GRP   (NUM_GRP),
    .GRP_W     (GRP_W),
    .GRP_BASE  (GRP_BASE),
    .GRP_STRIDE(GRP_STRIDE)
  ) u_dec (
    .addr(bus_addr),
    .hit (dec_hit),
    .grp (dec_grp),
    .sel (dec_sel)
  );

  // Write staging register: writes reach the banks one cycle later
  logic             wr_v_q;
  logic [GRP_W-1:0] wr_grp_q;
  gpio_sel_e        wr_sel_q;
  logic [REG_W-1:0] wr_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_v_q    <= 1'b0;
      wr_grp_q  <= '0;
      wr_sel_q  <= SEL_DIR;
      wr_data_q <= '0;
    end else begin
      wr_v_q    <= bus_wr && dec_hit;
      wr_grp_q  <= dec_grp;
      wr_sel_q  <= dec_sel;
      wr_data_q <= bus_wdata;
    end
  end

  logic [NUM_PINS-1:0] dir_all;
  logic [NUM_PINS-1:0] out_all;
  logic [NUM_PINS-1:0] in_all;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_bank
    localparam int W = grp_width(NUM_PINS, g);
    logic [W-1:0] b_dir, b_out, b_in;

    gpio_bank #(.W(W)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .wr_v   (wr_v_q && (wr_grp_q == GRP_W'(g))),
      .wr_sel (wr_sel_q),
      .wr_data(wr_data_q[W-1:0]),
      .pin_i  (pad_in[g*REG_W +: W]),
      .dir_o  (b_dir),
      .out_o  (b_out),
      .in_o   (b_in)
    );

    assign dir_all[g*REG_W +: W] = b_dir;
    assign out_all[g*REG_W +: W] = b_out;
    assign in_all[g*REG_W +: W]  = b_in;
  end

  assign pad_out = out_all;
  assign pad_oe  = ~dir_all;

  // Read path, zero-extended to whole groups
  logic [PAD_W-1:0] dir_pad, out_pad, in_pad;
  assign dir_pad = PAD_W'(dir_all);
  assign out_pad = PAD_W'(out_all);
  assign in_pad  = PAD_W'(in_all);

  logic [REG_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (dec_hit) begin
      case (dec_sel)
        SEL_DIR: rd_word = dir_pad[int'(dec_grp) * REG_W +: REG_W];
        SEL_OUT: rd_word = out_pad[int'(dec_grp) * REG_W +: REG_W];
        SEL_IN:  rd_word = in_pad[int'(dec_grp) * REG_W +: REG_W];
        default: rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_word;
  end

  // R10: unmapped offsets read zero on the following cycle
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !dec_hit |=> rd_data == '0);

  // R7: a newly captured write leaves the pads alone for one cycle
  p_write_stage_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && dec_hit && !wr_v_q) |=> ($stable(pad_out) && $stable(pad_oe)));

  // R2: output enable can only move one cycle after a staged write
  p_oe_after_stage_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(pad_oe) |-> $past(wr_v_q && wr_sel_q == SEL_DIR));

  if (LAST_W < REG_W) begin : g_last_pad
    // R9: missing bits of the last group never read as one
    p_last_grp_zero_r9: assert property (@(posedge clk) disable iff (rst)
      (dec_hit && dec_grp == GRP_W'(NUM_GRP - 1)) |=> rd_data[REG_W-1:LAST_W] == '0);
  end
endmodule

// File: tb/tb_gpio_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_ctrl;
  localparam int NP = 71;
  localparam int NG = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   rd_data;
  logic [NP-1:0] pad_in;
  logic [NP-1:0] pad_out;
  logic [NP-1:0] pad_oe;
  logic [NP-1:0] ext_drv = '0;

  always #4 clk = ~clk;   // 125 MHz

  // Output pins loop back, input pins see the external driver
  for (genvar i = 0; i < NP; i++) begin : g_pad
    assign pad_in[i] = pad_oe[i] ? pad_out[i] : ext_drv[i];
  end

  gpio_ctrl dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] m_dir [NG];
  logic [31:0] m_out [NG];

  function automatic logic [31:0] gmask(int g);
    return (g == NG - 1) ? 32'h0000_007F : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [7:0] ra(int g, int off);
    return 8'(16 + 40 * g + off);
  endfunction

  function automatic logic [31:0] m_in(int g);
    logic [95:0] e;
    e = 96'(ext_drv);
    return ((m_out[g] & ~m_dir[g]) | (e[g*32 +: 32] & m_dir[g])) & gmask(g);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    for (int g = 0; g < NG; g++) begin
      if (a == ra(g, 0))  m_dir[g] = d & gmask(g);
      if (a == ra(g, 4))  m_out[g] = d & gmask(g);
      if (a == ra(g, 8))  m_out[g] = m_out[g] | (d & gmask(g));
      if (a == ra(g, 12)) m_out[g] = m_out[g] & ~(d & gmask(g));
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] v);
    bus_addr = a; bus_wr = 1'b0;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 pad_oe lo", pad_oe[31:0], 32'h0);
    chk("R1 pad_oe hi", 32'(pad_oe[70:32]), 32'h0);
    for (int g = 0; g < NG; g++) begin
      rd(ra(g, 0), v); chk("R1 dir", v, gmask(g));
      rd(ra(g, 4), v); chk("R1 out", v, 32'h0);
    end
  endtask

  task automatic t_dir();
    logic [31:0] v;
    wr(ra(0, 0), 32'hFFFF_00FF);
    idle(1);
    chk("R2 pad_oe", pad_oe[31:0], 32'h0000_FF00);
    rd(ra(0, 0), v); chk("R2 dir readback", v, m_dir[0]);
  endtask

  task automatic t_out_set_clr();
    logic [31:0] v;
    wr(ra(0, 4), 32'h0000_00F0);
    idle(1);
    rd(ra(0, 4), v); chk("R5 out write", v, 32'h0000_00F0);
    chk("R5 pad_out follows latch", pad_out[31:0], 32'h0000_00F0);
    wr(ra(0, 8), 32'h0000_0F0F);
    idle(1);
    rd(ra(0, 4), v); chk("R3 set", v, 32'h0000_0FFF);
    wr(ra(0, 12), 32'h0000_0330);
    idle(1);
    rd(ra(0, 4), v); chk("R4 clear", v, 32'h0000_0CCF);
    chk("R4 pad_out", pad_out[31:0], 32'h0000_0CCF);
  endtask

  task automatic t_latency();
    logic [31:0] v;
    wr(ra(0, 8), 32'h1000_0000);
    rd(ra(0, 4), v); chk("R7 pre-write value", v, 32'h0000_0CCF);
    rd(ra(0, 4), v); chk("R7 post-write value", v, 32'h1000_0CCF);
  endtask

  task automatic t_input();
    logic [31:0] v, old;
    old = m_in(1);
    ext_drv[63:32] = 32'hA5A5_5A5A;
    rd(ra(1, 16), v); chk("R6 input lag", v, old);
    idle(3);
    rd(ra(1, 16), v); chk("R6 input settled", v, m_in(1));
    old = m_in(0);
    wr(ra(0, 8), 32'h0000_3000);
    rd(ra(0, 16), v); chk("R6 output readback lag", v, old);
    idle(4);
    rd(ra(0, 16), v); chk("R6 output readback", v, m_in(0));
  endtask

  task automatic t_map();
    logic [31:0] v;
    wr(ra(1, 0), 32'hFFFF_FEFF);
    wr(ra(1, 8), 32'h0000_0100);
    idle(1);
    chk("R8 pin40 out", 32'(pad_out[40]), 32'h1);
    chk("R8 pin40 oe", 32'(pad_oe[40]), 32'h1);
    chk("R8 group1 only pin40", pad_out[63:32], 32'h0000_0100);
    wr(ra(2, 0), 32'h0000_0000);
    wr(ra(2, 8), 32'h0000_0040);
    idle(1);
    chk("R8 pin70 out", 32'(pad_out[70:64]), 32'h40);
    chk("R8 pin70 oe", 32'(pad_oe[70:64]), 32'h7F);
    rd(ra(2, 4), v); chk("R8 group2 latch", v, 32'h40);
  endtask

  task automatic t_unimpl();
    logic [31:0] v;
    wr(ra(2, 4), 32'hFFFF_FFFF);
    idle(1);
    rd(ra(2, 4), v); chk("R9 out upper zero", v, 32'h0000_007F);
    wr(ra(2, 0), 32'hFFFF_FF80);
    idle(1);
    rd(ra(2, 0), v); chk("R9 dir upper zero", v, 32'h0);
    rd(ra(2, 16), v); chk("R9 input upper zero", v, m_in(2));
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    logic [7:0] bad [4] = '{8'h24, 8'h00, 8'h88, 8'h12};
    for (int k = 0; k < 4; k++) wr(bad[k], 32'hDEAD_BEEF);
    idle(1);
    for (int k = 0; k < 4; k++) begin
      rd(bad[k], v); chk("R10 unmapped reads zero", v, 32'h0);
    end
    rd(ra(0, 8), v);  chk("R10 set port reads zero", v, 32'h0);
    rd(ra(1, 12), v); chk("R10 clear port reads zero", v, 32'h0);
    for (int g = 0; g < NG; g++) begin
      rd(ra(g, 0), v); chk("R10 dir untouched", v, m_dir[g]);
      rd(ra(g, 4), v); chk("R10 out untouched", v, m_out[g]);
    end
  endtask

  initial begin
    for (int g = 0; g < NG; g++) begin
      m_dir[g] = gmask(g);
      m_out[g] = 32'h0;
    end
    idle(4);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_dir();
    t_out_set_clr();
    t_latency();
    t_input();
    t_map();
    t_unimpl();
    t_unmapped();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule